// File: doc/BRIEF.md
# Scan-Strobed Up Counter with Optional One-Shot Input

This block reproduces the count-up behaviour of a programmable-controller counter in hardware. Nothing moves except on a scan strobe. On each strobe the block looks at the input condition, updates an internal edge-memory bit and the accumulator, applies a pending clear command, and then recomputes the done flag against a preset value.

Counting is gated by the stored memory bit, not by a registered copy of the input. A clear command wipes that memory bit, so a condition that stays true is counted again on the next scan. An optional one-shot stage in front of the counter avoids this. When enabled, it presents the condition as true for only one scan per rising edge of the raw input.

Top module: `scan_up_counter`

## Requirements
- R1: On a scan where the condition seen by the counter is true and the memory bit is already set, the accumulator keeps its value.
- R2: On a scan where the seen condition is true and the memory bit is clear, the memory bit becomes 1 and the accumulator increases by one.
- R3: On a scan where the seen condition is false, the memory bit becomes 0 and the accumulator keeps its value.
- R4: A clear command on a scan sets the accumulator to 0 and the memory bit to 0, whatever the condition. It is applied after the count step of the same scan.
- R5: After a clear, if the raw input is still true and the one-shot is off, the next scan counts again and the accumulator becomes 1.
- R6: On every scan, including scans where the condition is false, done is recomputed as accumulator >= preset, using the accumulator value after the count and clear steps.
- R7: With the one-shot enabled (oneshot_en = 1), the counter sees a true condition only on the first scan where the raw input is 1 after a scan where it was 0. The one-shot storage bit follows the raw input on every scan.
- R8: With the one-shot enabled, a clear issued while the raw input is held true causes no extra count on later scans.
- R9: The accumulator wraps from its maximum value (2^W - 1) to 0 without any flag.
- R10: When scan is 0, the accumulator, memory bit, done flag and one-shot storage all hold, whatever the inputs do.
- R11: The synchronous reset sets the accumulator, memory bit, done flag and one-shot storage bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan | input | 1 | Scan strobe; state updates only when this is 1 |
| cond_raw | input | 1 | Raw input condition |
| oneshot_en | input | 1 | 1 selects the one-shot conditioned input |
| clr_cmd | input | 1 | Clear command, applied on a scan |
| preset | input | W | Preset that done is compared against |
| acc | output | W | Accumulator |
| done | output | 1 | Accumulator >= preset, as of the last scan |
| mem_up | output | 1 | Count-up edge-memory bit |

## Verification
The main function is driven with several input patterns, and each one separates behaviours that could be confused:
- A held-true raw input separates memory-bit gating from a simple re-trigger on every scan.
- Alternating raw input checks that every rising edge counts.
- A clear while the input is held true, with the one-shot off, must produce the recount.
- The same clear with the one-shot on must not recount.
- A false-condition scan after a preset change shows that done is re-evaluated without a count.
- A clear with preset zero shows that done is evaluated after the clear.
- A long toggling run checks the wrap.
- Idle cycles with the inputs toggling check that nothing changes between strobes.

// File: rtl/scan_ctr_pkg.sv
package scan_ctr_pkg;
    localparam int unsigned ACC_W_DEF = 16;

    typedef struct packed {
        logic mem;
        logic done;
    } ctr_flags_t;
endpackage

// File: rtl/scan_oneshot.sv
module scan_oneshot (
    input  logic clk,
    input  logic rst,
    input  logic scan,
    input  logic raw_i,
    input  logic en_i,
    output logic cond_o
);
    logic store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (scan) begin
            store_d = raw_i;
        end
        cond_o = en_i ? (raw_i & ~store_q) : raw_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= 1'b0;
        end else begin
            store_q <= store_d;
        end
    end

    // R7: a one-shot pulse taken on a scan cannot repeat on the following cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (scan && en_i && cond_o) |=> !(en_i && cond_o));

    // R10: storage holds between strobes
    a_r10_store_hold: assert property (@(posedge clk) disable iff (rst)
        !scan |=> $stable(store_q));
endmodule

// File: rtl/scan_count_core.sv
module scan_count_core
    import scan_ctr_pkg::*;
#(
    parameter int unsigned W = ACC_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scan,
    input  logic         cond_i,
    input  logic         clr_i,
    input  logic [W-1:0] preset_i,
    output logic [W-1:0] acc_o,
    output logic         done_o,
    output logic         mem_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] acc_d, acc_q;
    ctr_flags_t   fl_d, fl_q;

    always_comb begin
        acc_d = acc_q;
        fl_d  = fl_q;
        if (scan) begin
            if (cond_i) begin
                if (!fl_q.mem) begin
                    fl_d.mem = 1'b1;
                    acc_d    = acc_q + ONE;
                end
            end else begin
                fl_d.mem = 1'b0;
            end
            if (clr_i) begin
                acc_d    = '0;
                fl_d.mem = 1'b0;
            end
            fl_d.done = (acc_d >= preset_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            fl_q  <= '0;
        end else begin
            acc_q <= acc_d;
            fl_q  <= fl_d;
        end
    end

    assign acc_o  = acc_q;
    assign done_o = fl_q.done;
    assign mem_o  = fl_q.mem;

    // R1
    a_r1_held_no_count: assert property (@(posedge clk) disable iff (rst)
        (scan && cond_i && fl_q.mem && !clr_i) |=> (acc_q == $past(acc_q)) && fl_q.mem);
    // R2, R9
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (scan && cond_i && !fl_q.mem && !clr_i) |=> fl_q.mem && (acc_q == $past(acc_q) + ONE));
    // R3
    a_r3_false_clears_mem: assert property (@(posedge clk) disable iff (rst)
        (scan && !cond_i && !clr_i) |=> !fl_q.mem && $stable(acc_q));
    // R4
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (scan && clr_i) |=> (acc_q == '0) && !fl_q.mem);
    // R6
    a_r6_done_compare: assert property (@(posedge clk) disable iff (rst)
        scan |=> (fl_q.done == (acc_q >= $past(preset_i))));
    // R10
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !scan |=> $stable(acc_q) && $stable(fl_q));
endmodule

// File: rtl/scan_up_counter.sv
module scan_up_counter
    import scan_ctr_pkg::*;
#(
    parameter int unsigned W = ACC_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scan,
    input  logic         cond_raw,
    input  logic         oneshot_en,
    input  logic         clr_cmd,
    input  logic [W-1:0] preset,
    output logic [W-1:0] acc,
    output logic         done,
    output logic         mem_up
);
    logic cond_seen;

    scan_oneshot u_shaper (
        .clk    (clk),
        .rst    (rst),
        .scan   (scan),
        .raw_i  (cond_raw),
        .en_i   (oneshot_en),
        .cond_o (cond_seen)
    );

    scan_count_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .scan     (scan),
        .cond_i   (cond_seen),
        .clr_i    (clr_cmd),
        .preset_i (preset),
        .acc_o    (acc),
        .done_o   (done),
        .mem_o    (mem_up)
    );

    // R11
    a_r11_sys_reset: assert property (@(posedge clk)
        rst |=> (acc == '0) && !done && !mem_up);
endmodule

// File: tb/scan_up_counter_bench.sv
`timescale 1ns/100ps
module scan_up_counter_bench;
    localparam int W = 8;
    localparam int NV = 16;

    logic clk = 1'b0;
    logic rst, scan, cond_raw, oneshot_en, clr_cmd;
    logic [W-1:0] preset, acc;
    logic done, mem_up;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    scan_up_counter #(.W(W)) u_scan_up_counter (
        .clk(clk), .rst(rst), .scan(scan), .cond_raw(cond_raw),
        .oneshot_en(oneshot_en), .clr_cmd(clr_cmd), .preset(preset),
        .acc(acc), .done(done), .mem_up(mem_up)
    );

    // {raw, oneshot, clr, preset, exp_acc, exp_done, exp_mem}
    localparam logic [20:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,8'd3,8'd1,1'b0,1'b1},  // R2 first count
        {1'b1,1'b0,1'b0,8'd3,8'd1,1'b0,1'b1},  // R1 held true
        {1'b0,1'b0,1'b0,8'd3,8'd1,1'b0,1'b0},  // R3 false scan
        {1'b1,1'b0,1'b0,8'd3,8'd2,1'b0,1'b1},  // R2
        {1'b0,1'b0,1'b0,8'd3,8'd2,1'b0,1'b0},  // R3
        {1'b1,1'b0,1'b0,8'd3,8'd3,1'b1,1'b1},  // R6 reach preset
        {1'b1,1'b0,1'b1,8'd3,8'd0,1'b0,1'b0},  // R4 clear while held
        {1'b1,1'b0,1'b0,8'd3,8'd1,1'b0,1'b1},  // R5 recount
        {1'b0,1'b0,1'b0,8'd1,8'd1,1'b1,1'b0},  // R6 done on false scan
        {1'b0,1'b0,1'b0,8'd5,8'd1,1'b0,1'b0},  // R6 preset raised
        {1'b1,1'b1,1'b0,8'd5,8'd2,1'b0,1'b1},  // R7 one-shot edge
        {1'b1,1'b1,1'b1,8'd5,8'd0,1'b0,1'b0},  // R8 clear while held
        {1'b1,1'b1,1'b0,8'd5,8'd0,1'b0,1'b0},  // R8 no extra count
        {1'b0,1'b1,1'b0,8'd5,8'd0,1'b0,1'b0},  // R7 raw falls
        {1'b1,1'b1,1'b0,8'd5,8'd1,1'b0,1'b1},  // R7 new edge
        {1'b1,1'b1,1'b1,8'd0,8'd0,1'b1,1'b0}   // R4 R6 clear then compare
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_scan(input logic r, input logic os, input logic c, input logic [W-1:0] p);
        @(negedge clk);
        cond_raw = r; oneshot_en = os; clr_cmd = c; preset = p; scan = 1'b1;
        @(negedge clk);
        scan = 1'b0; clr_cmd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held_acc;
        logic held_mem, held_done;
        rst = 1'b1; scan = 1'b0; cond_raw = 1'b0; oneshot_en = 1'b0;
        clr_cmd = 1'b0; preset = '0;
        do_reset();
        chk("R11 reset acc", acc, 0);
        chk("R11 reset done", done, 0);
        chk("R11 reset mem", mem_up, 0);

        for (int i = 0; i < NV; i++) begin
            do_scan(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17:10]);
            chk($sformatf("vec%0d acc (R1-R8 table)", i), acc, VEC[i][9:2]);
            chk($sformatf("vec%0d done R6", i), done, VEC[i][1]);
            chk($sformatf("vec%0d mem", i), mem_up, VEC[i][0]);
        end

        // R10: no scan, inputs toggle, nothing moves
        do_scan(1'b1, 1'b0, 1'b0, 8'd2);
        held_acc = acc; held_mem = mem_up; held_done = done;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cond_raw = k[0]; clr_cmd = 1'b1; oneshot_en = k[1]; preset = 8'(k);
        end
        @(negedge clk);
        clr_cmd = 1'b0;
        chk("R10 acc hold", acc, held_acc);
        chk("R10 mem hold", mem_up, held_mem);
        chk("R10 done hold", done, held_done);

        // R11: reset clears the one-shot storage too
        do_scan(1'b1, 1'b1, 1'b0, 8'd9);
        do_reset();
        chk("R11 acc after reset", acc, 0);
        do_scan(1'b1, 1'b1, 1'b0, 8'd9);
        chk("R11 one-shot storage cleared", acc, 1);

        // R9: wrap at 2^W
        do_reset();
        for (int n = 0; n < (1 << W); n++) begin
            do_scan(1'b1, 1'b0, 1'b0, 8'hFF);
            if (n == (1 << W) - 2) chk("R9 max value", acc, (1 << W) - 1);
            do_scan(1'b0, 1'b0, 1'b0, 8'hFF);
        end
        chk("R9 wrapped to zero", acc, 0);
        chk("R9 done after wrap", done, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule